// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block keeps a few byte-wide configuration registers behind a simple register bus. The bus has an offset, a write strobe, write data and combinational read data. The registers hold:

- access wait counts for two peripheral register windows;
- interrupt and low-power enables for the serial-bus controller;
- wait selects for two on-chip RAMs;
- a boot-mode value latched from pins at reset, with a boot-area source bit;
- RAM placement and RAM configuration selects.

Each field is also driven onto a dedicated output for the logic that uses it.

A separate key register guards most of the bank. The bank opens only while the key register holds the unlock code 0x96. Any other value written to the key register closes the bank again. While the bank is closed, writes to guarded fields are dropped without any error. Two fields are exempt from the lock and stay writable at all times.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset the reads return the following values:
  - offset 0x10 reads 0x07;
  - offset 0x12 reads 0x07;
  - offset 0x14 reads 0x03;
  - offset 0x16 reads {boot pins, 4'b0010};
  - offset 0x18 reads 0x01;
  - the key register at offset 0x20 reads 0x00, so the bank starts locked.
- R2: Writing 0x96 to offset 0x20 unlocks the bank. A guarded write issued one cycle or more later takes effect, and its new value reads back in the cycle after the write.
- R3: Writing any value other than 0x96 to offset 0x20 relocks the bank. Later guarded writes are then dropped.
- R4: While locked, a write to a guarded field leaves it unchanged. The guarded fields are:
  - rtc wait, offset 0x10 bits 2:0;
  - usb wait, offset 0x12 bits 2:0;
  - usb interrupt enable, offset 0x12 bit 6;
  - core RAM wait, offset 0x14 bit 1;
  - internal boot enable, offset 0x16 bit 1;
  - RAM configuration select, offset 0x18 bit 4;
  - video RAM placement, offset 0x18 bit 0.
- R5: The usb snooze enable (offset 0x12 bit 5) and the video RAM wait (offset 0x14 bit 0) take every write, locked or not. In the same write, the guarded bits of that byte keep their lock behaviour.
- R6: Bits of a mapped offset that hold no field read 0, and writes to them have no effect.
- R7: Offset 0x16 bits 7:4 are read-only. They hold the boot pins sampled on the first clock edge after reset release, and that value does not change until the next reset.
- R8: The key register reads back the last byte written to it.
- R9: Unmapped offsets read 0, and writes to them change no register.
- R10: Each field output equals the matching register bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_pins_i | input | 4 | Boot-mode pins, sampled once after reset |
| addr_i | input | 6 | Register offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| rtc_wait_o | output | 3 | rtc window wait cycles, 0 to 7 |
| usb_wait_o | output | 3 | usb window wait cycles, 0 to 7 |
| usb_irq_en_o | output | 1 | usb interrupt enable |
| usb_snooze_o | output | 1 | usb snooze enable |
| core_ram_wait_o | output | 1 | Core RAM wait, 1 = one cycle |
| vid_ram_wait_o | output | 1 | Video RAM wait, 1 = one cycle |
| boot_int_o | output | 1 | Boot area source, 1 = internal |
| boot_mode_o | output | 4 | Latched boot mode: 1000 serial, 0100 parallel ROM, others reserved |
| ram_cfg_o | output | 1 | RAM configuration select |
| vram_loc_o | output | 1 | Video RAM placement select |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that addr_i, we_i and wdata_i are known and stable across each rising edge, with at most one write per cycle. The bench drives every bus input one time unit after a rising edge and holds it until the next edge. It samples read data and field outputs on the falling edge. It changes the boot pins only while reset is released and the value has already been latched.

// File: rtl/cfg_lock_bank_pkg.sv
package cfg_lock_bank_pkg;
  parameter int ADDR_W = 6;
  parameter int DATA_W = 8;
  parameter int WAIT_W = 3;
  parameter int BOOT_W = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t OFS_RTC  = addr_t'(6'h10);
  localparam addr_t OFS_USB  = addr_t'(6'h12);
  localparam addr_t OFS_RAMW = addr_t'(6'h14);
  localparam addr_t OFS_BOOT = addr_t'(6'h16);
  localparam addr_t OFS_PLC  = addr_t'(6'h18);
  localparam addr_t OFS_KEY  = addr_t'(6'h20);

  localparam data_t UNLOCK_KEY = data_t'(8'h96);
endpackage

// File: rtl/cfg_field.sv
module cfg_field #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST     = '0,
  parameter bit             GUARDED = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         unlock_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] q_o
);
  logic         en;
  logic [W-1:0] q_q;

  generate
    if (GUARDED) begin : g_guard
      assign en = wr_i & unlock_i;

      AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !unlock_i) |=> $stable(q_o)); // R4
      AST_OPEN_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && unlock_i) |=> (q_o == $past(wd_i))); // R2
    end else begin : g_free
      assign en = wr_i;

      AST_FREE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (q_o == $past(wd_i))); // R5
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= RST;
    else if (en)  q_q <= wd_i;
  end

  assign q_o = q_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o)); // R9
endmodule

// File: rtl/cfg_key_guard.sv
module cfg_key_guard
  import cfg_lock_bank_pkg::*;
#(
  parameter data_t KEY = UNLOCK_KEY
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  data_t wd_i,
  output data_t key_o,
  output logic  unlock_o
);
  data_t key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_q <= '0;
    else if (wr_i) key_q <= wd_i;
  end

  assign key_o    = key_q;
  assign unlock_o = (key_q == KEY);

  AST_KEY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i == KEY) |=> unlock_o); // R2
  AST_OTHER_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i != KEY) |=> !unlock_o); // R3
  AST_KEY_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (key_o == $past(wd_i))); // R8
endmodule

// File: rtl/cfg_boot_latch.sv
module cfg_boot_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] mode_o
);
  logic         done_q;
  logic [W-1:0] mode_q;

  // capture once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      mode_q <= '0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      mode_q <= pins_i;
    end
  end

  assign mode_o = mode_q;

  AST_BOOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(mode_o)); // R7
  AST_BOOT_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |=> (mode_o == $past(pins_i))); // R7
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BOOT_W-1:0] boot_pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [WAIT_W-1:0] rtc_wait_o,
  output logic [WAIT_W-1:0] usb_wait_o,
  output logic              usb_irq_en_o,
  output logic              usb_snooze_o,
  output logic              core_ram_wait_o,
  output logic              vid_ram_wait_o,
  output logic              boot_int_o,
  output logic [BOOT_W-1:0] boot_mode_o,
  output logic              ram_cfg_o,
  output logic              vram_loc_o
);
  localparam logic [WAIT_W-1:0] WAIT_RST = '1;

  logic  wr_rtc, wr_usb, wr_ramw, wr_boot, wr_plc, wr_key;
  logic  unlock;
  data_t key_val;

  assign wr_rtc  = we_i && (addr_i == OFS_RTC);
  assign wr_usb  = we_i && (addr_i == OFS_USB);
  assign wr_ramw = we_i && (addr_i == OFS_RAMW);
  assign wr_boot = we_i && (addr_i == OFS_BOOT);
  assign wr_plc  = we_i && (addr_i == OFS_PLC);
  assign wr_key  = we_i && (addr_i == OFS_KEY);

  cfg_key_guard u_key (
    .clk_i, .rst_ni, .wr_i(wr_key), .wd_i(wdata_i),
    .key_o(key_val), .unlock_o(unlock)
  );

  cfg_field #(.W(WAIT_W), .RST(WAIT_RST), .GUARDED(1'b1)) u_rtc_wait (
    .clk_i, .rst_ni, .wr_i(wr_rtc), .unlock_i(unlock),
    .wd_i(wdata_i[WAIT_W-1:0]), .q_o(rtc_wait_o)
  );
  cfg_field #(.W(WAIT_W), .RST(WAIT_RST), .GUARDED(1'b1)) u_usb_wait (
    .clk_i, .rst_ni, .wr_i(wr_usb), .unlock_i(unlock),
    .wd_i(wdata_i[WAIT_W-1:0]), .q_o(usb_wait_o)
  );
  cfg_field #(.W(1), .RST(1'b0), .GUARDED(1'b1)) u_usb_irq (
    .clk_i, .rst_ni, .wr_i(wr_usb), .unlock_i(unlock),
    .wd_i(wdata_i[6]), .q_o(usb_irq_en_o)
  );
  cfg_field #(.W(1), .RST(1'b0), .GUARDED(1'b0)) u_usb_snooze (
    .clk_i, .rst_ni, .wr_i(wr_usb), .unlock_i(unlock),
    .wd_i(wdata_i[5]), .q_o(usb_snooze_o)
  );
  cfg_field #(.W(1), .RST(1'b1), .GUARDED(1'b1)) u_core_wait (
    .clk_i, .rst_ni, .wr_i(wr_ramw), .unlock_i(unlock),
    .wd_i(wdata_i[1]), .q_o(core_ram_wait_o)
  );
  cfg_field #(.W(1), .RST(1'b1), .GUARDED(1'b0)) u_vid_wait (
    .clk_i, .rst_ni, .wr_i(wr_ramw), .unlock_i(unlock),
    .wd_i(wdata_i[0]), .q_o(vid_ram_wait_o)
  );
  cfg_field #(.W(1), .RST(1'b1), .GUARDED(1'b1)) u_boot_int (
    .clk_i, .rst_ni, .wr_i(wr_boot), .unlock_i(unlock),
    .wd_i(wdata_i[1]), .q_o(boot_int_o)
  );
  cfg_field #(.W(1), .RST(1'b0), .GUARDED(1'b1)) u_ram_cfg (
    .clk_i, .rst_ni, .wr_i(wr_plc), .unlock_i(unlock),
    .wd_i(wdata_i[4]), .q_o(ram_cfg_o)
  );
  cfg_field #(.W(1), .RST(1'b1), .GUARDED(1'b1)) u_vram_loc (
    .clk_i, .rst_ni, .wr_i(wr_plc), .unlock_i(unlock),
    .wd_i(wdata_i[0]), .q_o(vram_loc_o)
  );

  cfg_boot_latch #(.W(BOOT_W)) u_boot (
    .clk_i, .rst_ni, .pins_i(boot_pins_i), .mode_o(boot_mode_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_RTC:  rdata_o[WAIT_W-1:0] = rtc_wait_o;
      OFS_USB: begin
        rdata_o[6]          = usb_irq_en_o;
        rdata_o[5]          = usb_snooze_o;
        rdata_o[WAIT_W-1:0] = usb_wait_o;
      end
      OFS_RAMW: rdata_o[1:0] = {core_ram_wait_o, vid_ram_wait_o};
      OFS_BOOT: begin
        rdata_o[7:4] = boot_mode_o;
        rdata_o[1]   = boot_int_o;
      end
      OFS_PLC: begin
        rdata_o[4] = ram_cfg_o;
        rdata_o[0] = vram_loc_o;
      end
      OFS_KEY:  rdata_o = key_val;
      default:  rdata_o = '0;
    endcase
  end

  AST_RSVD_RTC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_RTC) |-> (rdata_o[7:3] == '0)); // R6
  AST_RSVD_PLC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_PLC) |-> (rdata_o[7:5] == '0 && rdata_o[3:1] == '0)); // R6
endmodule

// File: tb/cfg_lock_bank_tb.sv
module cfg_lock_bank_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] boot_pins = 4'b1000;
  logic [5:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] rtc_wait, usb_wait;
  logic       usb_irq_en, usb_snooze, core_wait, vid_wait, boot_int, ram_cfg, vram_loc;
  logic [3:0] boot_mode;

  always #2.5 clk = ~clk;

  cfg_lock_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .boot_pins_i(boot_pins), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .rtc_wait_o(rtc_wait),
    .usb_wait_o(usb_wait), .usb_irq_en_o(usb_irq_en), .usb_snooze_o(usb_snooze),
    .core_ram_wait_o(core_wait), .vid_ram_wait_o(vid_wait), .boot_int_o(boot_int),
    .boot_mode_o(boot_mode), .ram_cfg_o(ram_cfg), .vram_loc_o(vram_loc)
  );

  typedef struct {
    bit          is_port;
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  wire [16:0] port_vec = {rtc_wait, usb_wait, usb_irq_en, usb_snooze, core_wait,
                          vid_wait, boot_int, boot_mode, ram_cfg, vram_loc};

  // monitor: compare queued expectations on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [16:0] act;
        it  = sb.pop_front();
        act = it.is_port ? port_vec : {9'b0, rdata};
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic do_reset(input logic [3:0] pins);
    @(posedge clk); #1;
    rst_ni = 1'b0; we = 1'b0; boot_pins = pins;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); // boot pins latched here
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    addr = a; we = 1'b0;
    sb.push_back('{1'b0, {9'b0, e}, tag});
  endtask

  task automatic chk_ports(input logic [16:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{1'b1, e, tag});
  endtask

  initial begin
    do_reset(4'b1000);
    // R1 reset values
    rd(6'h10, 8'h07, "R1 rtc reset");
    rd(6'h12, 8'h07, "R1 usb reset");
    rd(6'h14, 8'h03, "R1 ram wait reset");
    rd(6'h16, 8'h82, "R1 boot reset");
    rd(6'h18, 8'h01, "R1 placement reset");
    rd(6'h20, 8'h00, "R1 key reset");
    chk_ports({3'd7, 3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1000, 1'b0, 1'b1}, "R10 reset ports");

    // R4 / R5 locked writes
    wr(6'h10, 8'h02); rd(6'h10, 8'h07, "R4 locked rtc");
    wr(6'h12, 8'hFF); rd(6'h12, 8'h27, "R5 snooze while locked");
    wr(6'h14, 8'h00); rd(6'h14, 8'h02, "R5 video wait while locked");
    wr(6'h18, 8'h00); rd(6'h18, 8'h01, "R4 locked placement");
    wr(6'h16, 8'h00); rd(6'h16, 8'h82, "R4 locked boot enable");

    // R2 / R8 unlock
    wr(6'h20, 8'h96); rd(6'h20, 8'h96, "R8 key readback");
    wr(6'h10, 8'hFD); rd(6'h10, 8'h05, "R2 R6 rtc unlocked");
    wr(6'h12, 8'h41); rd(6'h12, 8'h41, "R2 usb unlocked");
    wr(6'h14, 8'h00); rd(6'h14, 8'h00, "R2 ram wait unlocked");
    wr(6'h18, 8'hFF); rd(6'h18, 8'h11, "R2 R6 placement unlocked");
    wr(6'h16, 8'h0D); rd(6'h16, 8'h80, "R7 boot nibble read-only");
    chk_ports({3'd5, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b1, 1'b1}, "R10 ports unlocked");

    // R3 relock
    wr(6'h20, 8'h95); rd(6'h20, 8'h95, "R3 R8 relock key");
    wr(6'h10, 8'h03); rd(6'h10, 8'h05, "R3 write after relock");
    wr(6'h12, 8'h27); rd(6'h12, 8'h61, "R3 R5 usb after relock");

    // R9 unmapped
    wr(6'h11, 8'hFF); rd(6'h11, 8'h00, "R9 unmapped read");
    wr(6'h3F, 8'hFF); rd(6'h3F, 8'h00, "R9 unmapped high");
    rd(6'h10, 8'h05, "R9 no side effect");
    rd(6'h20, 8'h95, "R9 key untouched");

    // R7 pins changing after capture
    boot_pins = 4'b0100;
    rd(6'h16, 8'h80, "R7 boot held");

    do_reset(4'b0100);
    rd(6'h16, 8'h42, "R7 boot recaptured");
    rd(6'h10, 8'h07, "R1 rtc after second reset");

    @(posedge clk); @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule